// File: doc/BRIEF.md
# Exception Return Legality Checker

This block judges an exception return before the core commits to it. The caller presents the saved status word, the current exception level, the link address, the current status word and a handful of configuration inputs. These inputs cover the 64-bit or 32-bit width of each level, the presence of level 2, secure state, the hypervisor trap-general control and whether single-step is active at the destination. The caller raises `valid` for one cycle.

One cycle later the block pulses `done` and presents its result. For a legal return, the result is the destination level, the execution state, the new status word and an aligned return address. For an illegal return, the core stays at its level and state. It receives a status word in which only the flags and interrupt masks come from the saved word and the illegal-state bit is set, and it resumes at the unmodified link address.

The decision is a single combinational path: saved-mode decode, then the legality rules, then result assembly. A register stage closes the path. Stack selection and register bank remapping belong to other logic.

Top module: `erl_return_check`

## Requirements
- R1: With saved bit 4 set (32-bit return), mode field [4:0] 0x10 gives level 0, 0x1A gives level 2, and 0x11, 0x12, 0x13, 0x17, 0x1B and 0x1F give level 1, each with execution state 32-bit.
- R2: With saved bit 4 set, mode 0x16 and every encoding not listed in R1 make the return illegal.
- R3: With saved bit 4 clear (64-bit return), a set bit 1, or bits [3:0] equal to 1, make the return illegal. Otherwise the destination level is bits [3:2].
- R4: A destination level above the current level is illegal. Destination level 2 without level 2 present is illegal.
- R5: A nonzero destination level whose configured width (`el_is64[level]`, 1 = 64-bit) differs from the width the saved word requests is illegal.
- R6: Destination level 2 while secure and below level 3 is illegal. Destination level 1 while trap-general is set is illegal.
- R7: A current level of 0 always makes the return illegal.
- R8: A legal return outputs the decoded level, the requested state (1 = 64-bit) and the saved word as the new status word.
- R9: A legal 32-bit return gives the link address with bit 0 cleared when saved bit 5 is set, and with bits [1:0] cleared otherwise. A legal 64-bit return passes the link address unchanged.
- R10: An illegal return keeps the current level and its configured state and outputs the unmodified link address. Its status word is the current word with bits [31:28] and [9:6] taken from the saved word and bit 20 set.
- R11: Bit 21 of the result status word is cleared unless `ss_active` is high.
- R12: `done` is high exactly in the cycle after a `valid` cycle. Without `valid`, all result outputs hold.
- R13: After reset, `done`, `illegal` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid | input | 1 | One-cycle request strobe |
| cur_el | input | 2 | Current exception level |
| saved_psr | input | 32 | Saved status word |
| cur_psr | input | 32 | Current status word |
| link_addr | input | 64 | Return link address |
| el_is64 | input | 4 | Per-level width, 1 = 64-bit |
| has_el2 | input | 1 | Level 2 is present |
| secure | input | 1 | Core is in secure state |
| trap_gen | input | 1 | Hypervisor trap-general control |
| ss_active | input | 1 | Single-step active at destination |
| done | output | 1 | Result strobe |
| illegal | output | 1 | Return judged illegal |
| tgt_el | output | 2 | Resulting exception level |
| tgt_is64 | output | 1 | Resulting state, 1 = 64-bit |
| new_psr | output | 32 | Resulting status word |
| ret_pc | output | 64 | Resulting program counter |

## Verification
The properties assume that every input is meaningful only in a `valid` cycle, so each one relates values sampled in that cycle to the outputs one edge later. None of them looks further back. They also assume that `valid` is low during reset. The bench holds `valid` low throughout reset. It changes inputs only on falling edges and drops `valid` after one cycle, so each request is seen exactly once. Between requests the bench alters the saved word to show that the outputs still hold.

// File: rtl/erl_pkg.sv
// Shared constants and types for the exception return checker.
// Assumes a 32-bit status word layout with fixed bit positions.
package erl_pkg;
    localparam int EL_W     = 2;
    localparam int NUM_EL   = 1 << EL_W;
    localparam int MODE_W   = 5;
    localparam int B_NRW    = 4;   // set: 32-bit return
    localparam int B_THUMB  = 5;
    localparam int B_IL     = 20;
    localparam int B_SS     = 21;
    localparam logic [31:0] KEEP_MASK = 32'hF000_03C0; // flags + masks

    localparam logic [MODE_W-1:0] M32_USR = 5'h10;
    localparam logic [MODE_W-1:0] M32_FIQ = 5'h11;
    localparam logic [MODE_W-1:0] M32_IRQ = 5'h12;
    localparam logic [MODE_W-1:0] M32_SVC = 5'h13;
    localparam logic [MODE_W-1:0] M32_ABT = 5'h17;
    localparam logic [MODE_W-1:0] M32_HYP = 5'h1A;
    localparam logic [MODE_W-1:0] M32_UND = 5'h1B;
    localparam logic [MODE_W-1:0] M32_SYS = 5'h1F;

    typedef struct packed {
        logic            bad;      // encoding cannot be returned to
        logic [EL_W-1:0] el;       // decoded destination level
        logic            want64;   // requested state is 64-bit
    } mode_dec_t;
endpackage

// File: rtl/erl_mode_dec.sv
// Decodes the saved mode field into a destination level and state.
// Assumes bit 4 of the field selects the 32-bit encoding space.
module erl_mode_dec
    import erl_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_dec_t         dec
);
    // Map the mode field for either execution state.
    always_comb begin
        dec.bad    = 1'b0;
        dec.el     = '0;
        dec.want64 = ~mode[B_NRW];
        if (mode[B_NRW]) begin
            unique case (mode)
                M32_USR: dec.el = 2'd0;
                M32_HYP: dec.el = 2'd2;
                M32_FIQ, M32_IRQ, M32_SVC,
                M32_ABT, M32_UND, M32_SYS: dec.el = 2'd1;
                default: dec.bad = 1'b1;
            endcase
        end else if (mode[1]) begin
            dec.bad = 1'b1;
        end else if (mode[3:0] == 4'd1) begin
            dec.bad = 1'b1;
        end else begin
            dec.el = mode[3:2];
        end
    end
endmodule

// File: rtl/erl_rules.sv
// Applies the layered legality rules to a decoded destination.
// Assumes el_is64 holds one width bit per level.
module erl_rules
    import erl_pkg::*;
(
    input  mode_dec_t         dec,
    input  logic [EL_W-1:0]   cur_el,
    input  logic [NUM_EL-1:0] el_is64,
    input  logic              has_el2,
    input  logic              secure,
    input  logic              trap_gen,
    output logic              illegal
);
    logic r_level, r_width, r_route;

    // Level ordering and presence checks.
    always_comb begin
        r_level = (cur_el == '0) || (dec.el > cur_el)
                  || (dec.el == 2'd2 && !has_el2);
    end

    // Width agreement for any nonzero destination.
    always_comb begin
        r_width = (dec.el != '0) && (el_is64[dec.el] != dec.want64);
    end

    // Security and hypervisor routing checks.
    always_comb begin
        r_route = (dec.el == 2'd2 && secure && cur_el != 2'd3)
                  || (dec.el == 2'd1 && trap_gen);
    end

    // Combine every rule into the verdict.
    always_comb begin
        illegal = dec.bad | r_level | r_width | r_route;
    end
endmodule

// File: rtl/erl_build.sv
// Assembles the resulting level, state, status word and PC.
// Assumes the verdict and decode come from the same request.
module erl_build
    import erl_pkg::*;
#(
    parameter int PSR_W = 32,
    parameter int PC_W  = 64
) (
    input  logic              illegal,
    input  mode_dec_t         dec,
    input  logic [EL_W-1:0]   cur_el,
    input  logic [NUM_EL-1:0] el_is64,
    input  logic [PSR_W-1:0]  saved_psr,
    input  logic [PSR_W-1:0]  cur_psr,
    input  logic [PC_W-1:0]   link_addr,
    input  logic              ss_active,
    output logic [EL_W-1:0]   el_o,
    output logic              is64_o,
    output logic [PSR_W-1:0]  psr_o,
    output logic [PC_W-1:0]   pc_o
);
    localparam logic [PSR_W-1:0] KEEP = PSR_W'(KEEP_MASK);
    logic [PSR_W-1:0] psr_pre;
    logic [PC_W-1:0]  align;

    // Alignment mask for a 32-bit destination.
    always_comb begin
        align = saved_psr[B_THUMB] ? ~PC_W'(1) : ~PC_W'(3);
    end

    // Select the legal or the partial-restore result.
    always_comb begin
        if (illegal) begin
            el_o    = cur_el;
            is64_o  = el_is64[cur_el];
            psr_pre = (cur_psr & ~KEEP) | (saved_psr & KEEP);
            psr_pre[B_IL] = 1'b1;
            pc_o    = link_addr;
        end else begin
            el_o    = dec.el;
            is64_o  = dec.want64;
            psr_pre = saved_psr;
            pc_o    = dec.want64 ? link_addr : (link_addr & align);
        end
    end

    // Drop the single-step bit unless stepping is active.
    always_comb begin
        psr_o = psr_pre;
        if (!ss_active) psr_o[B_SS] = 1'b0;
    end
endmodule

// File: rtl/erl_return_check.sv
// Top of the exception return checker: decode, rules, build, register.
// Assumes valid is a one-cycle strobe; results hold between requests.
module erl_return_check
    import erl_pkg::*;
#(
    parameter int PSR_W = 32,
    parameter int PC_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [EL_W-1:0]   cur_el,
    input  logic [PSR_W-1:0]  saved_psr,
    input  logic [PSR_W-1:0]  cur_psr,
    input  logic [PC_W-1:0]   link_addr,
    input  logic [NUM_EL-1:0] el_is64,
    input  logic              has_el2,
    input  logic              secure,
    input  logic              trap_gen,
    input  logic              ss_active,
    output logic              done,
    output logic              illegal,
    output logic [EL_W-1:0]   tgt_el,
    output logic              tgt_is64,
    output logic [PSR_W-1:0]  new_psr,
    output logic [PC_W-1:0]   ret_pc
);
    mode_dec_t        dec;
    logic             bad_c;
    logic [EL_W-1:0]  el_c;
    logic             is64_c;
    logic [PSR_W-1:0] psr_c;
    logic [PC_W-1:0]  pc_c;

    erl_mode_dec u_dec (
        .mode (saved_psr[MODE_W-1:0]),
        .dec  (dec)
    );

    erl_rules u_rules (
        .dec      (dec),
        .cur_el   (cur_el),
        .el_is64  (el_is64),
        .has_el2  (has_el2),
        .secure   (secure),
        .trap_gen (trap_gen),
        .illegal  (bad_c)
    );

    erl_build #(.PSR_W(PSR_W), .PC_W(PC_W)) u_build (
        .illegal   (bad_c),
        .dec       (dec),
        .cur_el    (cur_el),
        .el_is64   (el_is64),
        .saved_psr (saved_psr),
        .cur_psr   (cur_psr),
        .link_addr (link_addr),
        .ss_active (ss_active),
        .el_o      (el_c),
        .is64_o    (is64_c),
        .psr_o     (psr_c),
        .pc_o      (pc_c)
    );

    // Output stage: strobe every cycle, capture results on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            illegal  <= 1'b0;
            tgt_el   <= '0;
            tgt_is64 <= 1'b0;
            new_psr  <= '0;
            ret_pc   <= '0;
        end else begin
            done <= valid;
            if (valid) begin
                illegal  <= bad_c;
                tgt_el   <= el_c;
                tgt_is64 <= is64_c;
                new_psr  <= psr_c;
                ret_pc   <= pc_c;
            end
        end
    end
endmodule

// File: rtl/erl_return_check_sva.sv
// Property checker for erl_return_check, attached by bind.
// Assumes valid is low while reset is asserted.
module erl_return_check_sva
    import erl_pkg::*;
#(
    parameter int PSR_W = 32,
    parameter int PC_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid,
    input logic [EL_W-1:0]   cur_el,
    input logic [PSR_W-1:0]  saved_psr,
    input logic [PC_W-1:0]   link_addr,
    input logic              trap_gen,
    input logic              ss_active,
    input logic              done,
    input logic              illegal,
    input logic [EL_W-1:0]   tgt_el,
    input logic [PSR_W-1:0]  new_psr,
    input logic [PC_W-1:0]   ret_pc
);
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> done);
    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> !done);
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> ($stable(new_psr) && $stable(ret_pc) && $stable(tgt_el)));
    p_mon_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && saved_psr[MODE_W-1:0] == 5'h16) |=> illegal);
    p_not_above_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (illegal || tgt_el <= $past(cur_el)));
    p_trap_gen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && trap_gen) |=> (illegal || tgt_el != 2'd1));
    p_cur_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && cur_el == '0) |=> illegal);
    p_illegal_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> (!illegal || (new_psr[B_IL] && ret_pc == $past(link_addr)
                                && tgt_el == $past(cur_el))));
    p_ss_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ss_active) |=> !new_psr[B_SS]);
endmodule

bind erl_return_check erl_return_check_sva #(.PSR_W(PSR_W), .PC_W(PC_W)) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (valid),
    .cur_el    (cur_el),
    .saved_psr (saved_psr),
    .link_addr (link_addr),
    .trap_gen  (trap_gen),
    .ss_active (ss_active),
    .done      (done),
    .illegal   (illegal),
    .tgt_el    (tgt_el),
    .new_psr   (new_psr),
    .ret_pc    (ret_pc)
);

// File: tb/erl_return_check_test.sv
module erl_return_check_test;
    localparam int PERIOD = 10;
    localparam int NV = 23;
    localparam logic [31:0] CUR_PSR = 32'h5000_0005;
    localparam logic [63:0] LINK    = 64'h0000_0000_1234_5677;
    localparam logic [31:0] KEEP    = 32'hF000_03C0;

    // Fields: cur_el[49:48] saved[47:16] is64[15:12] el2[11] sec[10]
    // tge[9] ss[8] exp_illegal[7] exp_el[6:5] exp_is64[4] req[3:0]
    localparam logic [49:0] VEC [0:NV-1] = '{
        {2'd2, 32'hA000_03C5, 4'b1111, 4'b1000, 1'b0, 2'd1, 1'b1, 4'd8},  // R8
        {2'd1, 32'hA000_0009, 4'b1111, 4'b1000, 1'b1, 2'd1, 1'b1, 4'd4},  // R4 above
        {2'd3, 32'h0000_0009, 4'b1111, 4'b0000, 1'b1, 2'd3, 1'b1, 4'd4},  // R4 no EL2
        {2'd3, 32'h0000_0002, 4'b1111, 4'b1000, 1'b1, 2'd3, 1'b1, 4'd3},  // R3 bit1
        {2'd1, 32'h0000_0001, 4'b1111, 4'b1000, 1'b1, 2'd1, 1'b1, 4'd3},  // R3 nibble 1
        {2'd1, 32'h0020_0000, 4'b1111, 4'b1000, 1'b0, 2'd0, 1'b1, 4'd11}, // R11 cleared
        {2'd1, 32'h0020_0000, 4'b1111, 4'b1001, 1'b0, 2'd0, 1'b1, 4'd11}, // R11 kept
        {2'd2, 32'h0000_0010, 4'b1110, 4'b1000, 1'b0, 2'd0, 1'b0, 4'd9},  // R9 mask 3
        {2'd1, 32'h0000_0030, 4'b1111, 4'b1000, 1'b0, 2'd0, 1'b0, 4'd9},  // R9 mask 1
        {2'd3, 32'h0000_0013, 4'b1101, 4'b1000, 1'b0, 2'd1, 1'b0, 4'd1},  // R1 SVC
        {2'd3, 32'h0000_0013, 4'b1111, 4'b1000, 1'b1, 2'd3, 1'b1, 4'd5},  // R5
        {2'd3, 32'h0000_0016, 4'b1111, 4'b1000, 1'b1, 2'd3, 1'b1, 4'd2},  // R2 MON
        {2'd3, 32'h0000_0014, 4'b1111, 4'b1000, 1'b1, 2'd3, 1'b1, 4'd2},  // R2 undefined
        {2'd3, 32'h0000_001A, 4'b1011, 4'b1000, 1'b0, 2'd2, 1'b0, 4'd1},  // R1 HYP
        {2'd3, 32'h0000_0009, 4'b1111, 4'b1100, 1'b0, 2'd2, 1'b1, 4'd6},  // R6 secure at 3
        {2'd2, 32'h0000_0009, 4'b1111, 4'b1100, 1'b1, 2'd2, 1'b1, 4'd6},  // R6 secure below 3
        {2'd2, 32'h0000_0005, 4'b1111, 4'b1010, 1'b1, 2'd2, 1'b1, 4'd6},  // R6 trap-general
        {2'd2, 32'h0000_0000, 4'b1111, 4'b1010, 1'b0, 2'd0, 1'b1, 4'd6},  // R6 EL0 allowed
        {2'd0, 32'h0000_0000, 4'b1111, 4'b1000, 1'b1, 2'd0, 1'b1, 4'd7},  // R7
        {2'd3, 32'h0000_001F, 4'b1101, 4'b1000, 1'b0, 2'd1, 1'b0, 4'd1},  // R1 SYS
        {2'd1, 32'h0000_0011, 4'b1101, 4'b1000, 1'b0, 2'd1, 1'b0, 4'd1},  // R1 FIQ
        {2'd3, 32'h0000_000D, 4'b1111, 4'b1000, 1'b0, 2'd3, 1'b1, 4'd3},  // R3 EL3
        {2'd2, 32'h0000_0005, 4'b1101, 4'b1000, 1'b1, 2'd2, 1'b1, 4'd5}   // R5 64 vs 32
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [1:0]  cur_el = '0;
    logic [31:0] saved_psr = '0;
    logic [31:0] cur_psr = CUR_PSR;
    logic [63:0] link_addr = LINK;
    logic [3:0]  el_is64 = '0;
    logic        has_el2 = 1'b0, secure = 1'b0, trap_gen = 1'b0, ss_active = 1'b0;
    logic        done, illegal, tgt_is64;
    logic [1:0]  tgt_el;
    logic [31:0] new_psr;
    logic [63:0] ret_pc;
    int          n_run = 0;
    int          n_fail = 0;
    bit          finished = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    erl_return_check uut (
        .clk(clk), .rst_n(rst_n), .valid(valid), .cur_el(cur_el),
        .saved_psr(saved_psr), .cur_psr(cur_psr), .link_addr(link_addr),
        .el_is64(el_is64), .has_el2(has_el2), .secure(secure),
        .trap_gen(trap_gen), .ss_active(ss_active), .done(done),
        .illegal(illegal), .tgt_el(tgt_el), .tgt_is64(tgt_is64),
        .new_psr(new_psr), .ret_pc(ret_pc)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset values
        check("R13", "done", 64'(done), 64'd0);
        check("R13", "illegal", 64'(illegal), 64'd0);
        check("R13", "new_psr", 64'(new_psr), 64'd0);
        check("R13", "ret_pc", ret_pc, 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            logic [31:0] sp, ep;
            logic [63:0] epc;
            string rq;
            v = VEC[i];
            sp = v[47:16];
            rq = $sformatf("R%0d", v[3:0]);
            cur_el = v[49:48]; saved_psr = sp; el_is64 = v[15:12];
            has_el2 = v[11]; secure = v[10]; trap_gen = v[9]; ss_active = v[8];
            valid = 1'b1;
            @(negedge clk);
            valid = 1'b0;
            if (v[7]) begin
                ep = (CUR_PSR & ~KEEP) | (sp & KEEP) | 32'h0010_0000;
                epc = LINK;
            end else begin
                ep = sp;
                epc = v[4] ? LINK : (sp[5] ? (LINK & ~64'd1) : (LINK & ~64'd3));
            end
            if (!v[8]) ep[21] = 1'b0;
            check("R12", $sformatf("v%0d done", i), 64'(done), 64'd1);
            check(rq, $sformatf("v%0d illegal", i), 64'(illegal), 64'(v[7]));
            check(rq, $sformatf("v%0d el", i), 64'(tgt_el), 64'(v[6:5]));
            check(rq, $sformatf("v%0d state", i), 64'(tgt_is64), 64'(v[4]));
            check(v[7] ? "R10" : "R8", $sformatf("v%0d psr", i), 64'(new_psr), 64'(ep));
            check(v[7] ? "R10" : "R9", $sformatf("v%0d pc", i), ret_pc, epc);
        end

        // R12: without valid, changed inputs leave results untouched
        begin
            logic [31:0] hold_psr;
            logic [63:0] hold_pc;
            hold_psr = new_psr; hold_pc = ret_pc;
            saved_psr = 32'hFFFF_FFFF; cur_el = 2'd3; link_addr = 64'h55;
            @(negedge clk);
            @(negedge clk);
            check("R12", "done idle", 64'(done), 64'd0);
            check("R12", "psr hold", 64'(new_psr), 64'(hold_psr));
            check("R12", "pc hold", ret_pc, hold_pc);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule